// File: doc/BRIEF.md
# Interrupt Status Summary Controller

This block keeps the status word of a network controller. Receive and transmit engines raise single-cycle event strobes. Each strobe latches a sticky bit in the status word. Software clears those bits by writing ones to them. A separate 32-bit enable word decides which latched events take part in interrupt generation.

Enabled events fall into two groups. The normal group covers completions and benign conditions, and the abnormal group covers errors and stalls. Each group drives one summary bit in the status word. The interrupt line is raised when a summary bit is set and that summary bit is itself enabled. The summary bits are recomputed on every update of the status or enable word, so they always follow the current contents.

The same status word also carries two 3-bit process-state fields, one for the receive engine and one for the transmit engine. Each engine writes its field through its own port, and host clears never touch these fields.

Top module: `isc_top`

## Requirements
- R1: After reset the status word reads 0xF0000000, the enable word reads 0xF3FE0000 and the interrupt line is low.
- R2: A strobe on an event position sets that status bit at the next clock edge. Event positions are 0 to 14, 26 and 27. Strobes on any other position are ignored.
- R3: A host write clears every event bit whose data bit is 1 and leaves bits written with 0 unchanged. Bits 31:28 and 25:23 and both state fields are never changed by a host write.
- R4: If an event strobe and a host clear hit the same bit in the same cycle, the bit ends up set.
- R5: Bit 16 (normal summary) is 1 exactly when status AND enable is nonzero at any of positions 0, 2, 6, 11 or 14.
- R6: Bit 15 (abnormal summary) is 1 exactly when status AND enable is nonzero at any of positions 1, 3, 4, 5, 7, 8, 9, 10, 12, 13, 26 or 27.
- R7: Both summary bits are recomputed on every update, including an enable-word write. Writing 1 to a summary bit therefore leaves it set while an enabled event of its group remains.
- R8: The interrupt line is registered. It is 1 when status AND enable has bit 15 or bit 16 set, and it changes at the same edge as the status word it reflects.
- R9: A receive-state write replaces all of bits 19:17 with the given value. A transmit-state write replaces all of bits 22:20.
- R10: An enable-word write loads all 32 bits at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtSet | input | 32 | Per-bit event set strobes |
| hostWrEn | input | 1 | Host write to status word (write-one-to-clear) |
| hostWrData | input | 32 | Host write data for status word |
| maskWrEn | input | 1 | Host write to enable word |
| maskWrData | input | 32 | New enable word |
| rxStateWr | input | 1 | Receive-state field load |
| rxStateVal | input | 3 | Receive-state value |
| txStateWr | input | 1 | Transmit-state field load |
| txStateVal | input | 3 | Transmit-state value |
| statusOut | output | 32 | Current status word |
| maskOut | output | 32 | Current enable word |
| irqOut | output | 1 | Level interrupt |

## Verification
A lost or stale latch shows on statusOut one edge after the strobe or clear that should have changed it. A summary bit computed from the wrong group, or from an old enable word, makes bit 15 or 16 disagree with the visible status and enable words in that same cycle. A mis-timed interrupt register shows as irqOut disagreeing with those two words at that edge. Because each wrong internal state shows at the next edge, the bench compares every port after every stimulus cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int DATA_W  = 32;
  localparam int STATE_W = 3;

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [STATE_W-1:0] pstate_t;

  // event bit positions
  localparam int POS_TX_DONE   = 0;
  localparam int POS_TX_STOP   = 1;
  localparam int POS_TX_NOBUF  = 2;
  localparam int POS_TX_JABBER = 3;
  localparam int POS_LINK_OK   = 4;
  localparam int POS_UNDERRUN  = 5;
  localparam int POS_RX_DONE   = 6;
  localparam int POS_RX_NOBUF  = 7;
  localparam int POS_RX_STOP   = 8;
  localparam int POS_RX_WDOG   = 9;
  localparam int POS_EARLY_TX  = 10;
  localparam int POS_TIMER     = 11;
  localparam int POS_LINK_DOWN = 12;
  localparam int POS_BUS_ERR   = 13;
  localparam int POS_EARLY_RX  = 14;
  localparam int POS_ABN_SUM   = 15;
  localparam int POS_NRM_SUM   = 16;
  localparam int RX_ST_LSB     = 17;
  localparam int TX_ST_LSB     = 20;
  localparam int POS_GP_PORT   = 26;
  localparam int POS_LINK_CHG  = 27;

  localparam word_t NORMAL_BITS =
      (word_t'(1) << POS_TX_DONE)  | (word_t'(1) << POS_TX_NOBUF) |
      (word_t'(1) << POS_RX_DONE)  | (word_t'(1) << POS_TIMER)    |
      (word_t'(1) << POS_EARLY_RX);

  localparam word_t ABNORMAL_BITS =
      (word_t'(1) << POS_TX_STOP)   | (word_t'(1) << POS_TX_JABBER) |
      (word_t'(1) << POS_LINK_OK)   | (word_t'(1) << POS_UNDERRUN)  |
      (word_t'(1) << POS_RX_NOBUF)  | (word_t'(1) << POS_RX_STOP)   |
      (word_t'(1) << POS_RX_WDOG)   | (word_t'(1) << POS_EARLY_TX)  |
      (word_t'(1) << POS_LINK_DOWN) | (word_t'(1) << POS_BUS_ERR)   |
      (word_t'(1) << POS_GP_PORT)   | (word_t'(1) << POS_LINK_CHG);

  localparam word_t EVENT_BITS   = NORMAL_BITS | ABNORMAL_BITS;
  localparam word_t SUMMARY_BITS = (word_t'(1) << POS_ABN_SUM) | (word_t'(1) << POS_NRM_SUM);
  localparam word_t CLEAR_BITS   = EVENT_BITS | SUMMARY_BITS;
  localparam word_t RX_FIELD     = word_t'({STATE_W{1'b1}}) << RX_ST_LSB;
  localparam word_t TX_FIELD     = word_t'({STATE_W{1'b1}}) << TX_ST_LSB;
  localparam word_t HOLD_BITS    = ~(CLEAR_BITS | RX_FIELD | TX_FIELD);

  localparam word_t STATUS_RST = 32'hF000_0000;
  localparam word_t MASK_RST   = 32'hF3FE_0000;

  typedef struct packed {
    word_t   setBits;
    word_t   clrBits;
    logic    rxLoad;
    pstate_t rxVal;
    logic    txLoad;
    pstate_t txVal;
    logic    maskLoad;
    word_t   maskVal;
  } ctl_strobes_t;
endpackage

// File: rtl/isc_group_or.sv
module isc_group_or
  import isc_pkg::*;
#(
  parameter word_t GROUP = NORMAL_BITS
) (
  input  word_t eventsIn,
  input  word_t maskIn,
  output logic  anyOut
);
  word_t enabled;
  assign enabled = eventsIn & maskIn & GROUP;
  assign anyOut  = |enabled;
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
(
  input  word_t        evtSet,
  input  logic         hostWrEn,
  input  word_t        hostWrData,
  input  logic         maskWrEn,
  input  word_t        maskWrData,
  input  logic         rxStateWr,
  input  pstate_t      rxStateVal,
  input  logic         txStateWr,
  input  pstate_t      txStateVal,
  output ctl_strobes_t strobes
);
  always_comb begin
    strobes          = '0;
    strobes.setBits  = evtSet & EVENT_BITS;
    strobes.clrBits  = hostWrEn ? (hostWrData & CLEAR_BITS) : '0;
    strobes.rxLoad   = rxStateWr;
    strobes.rxVal    = rxStateVal;
    strobes.txLoad   = txStateWr;
    strobes.txVal    = txStateVal;
    strobes.maskLoad = maskWrEn;
    strobes.maskVal  = maskWrData;
  end
endmodule

// File: rtl/isc_datapath.sv
module isc_datapath
  import isc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctl_strobes_t strobes,
  output word_t        statusQ,
  output word_t        maskQ,
  output logic         irqQ
);
  word_t evNext;
  word_t maskNext;
  word_t statusNext;
  logic  nrmSum;
  logic  abnSum;

  // per-bit sticky latch: a set beats a clear in the same cycle
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (EVENT_BITS[b]) begin : g_evt
      assign evNext[b] = strobes.setBits[b] | (statusQ[b] & ~strobes.clrBits[b]);
    end else begin : g_none
      assign evNext[b] = 1'b0;
    end
  end

  assign maskNext = strobes.maskLoad ? strobes.maskVal : maskQ;

  isc_group_or #(.GROUP(NORMAL_BITS)) u_nrm (
    .eventsIn(evNext), .maskIn(maskNext), .anyOut(nrmSum));
  isc_group_or #(.GROUP(ABNORMAL_BITS)) u_abn (
    .eventsIn(evNext), .maskIn(maskNext), .anyOut(abnSum));

  always_comb begin
    statusNext = (statusQ & HOLD_BITS) | evNext;
    statusNext[RX_ST_LSB +: STATE_W] = strobes.rxLoad ? strobes.rxVal
                                                      : statusQ[RX_ST_LSB +: STATE_W];
    statusNext[TX_ST_LSB +: STATE_W] = strobes.txLoad ? strobes.txVal
                                                      : statusQ[TX_ST_LSB +: STATE_W];
    statusNext[POS_NRM_SUM] = nrmSum;
    statusNext[POS_ABN_SUM] = abnSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= STATUS_RST;
      maskQ   <= MASK_RST;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      maskQ   <= maskNext;
      irqQ    <= |(statusNext & maskNext & SUMMARY_BITS);
    end
  end

  // R4: every requested set is visible at the next edge
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|strobes.setBits) |=> ((statusQ & $past(strobes.setBits)) == $past(strobes.setBits)));

  // R3: a clear without a matching set leaves the bit low
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (|(strobes.clrBits & ~strobes.setBits & EVENT_BITS)) |=>
      ((statusQ & $past(strobes.clrBits & ~strobes.setBits & EVENT_BITS)) == '0));

  // R5: normal summary agrees with visible words
  p_nrm_sum_r5: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[POS_NRM_SUM] == (|(statusQ & maskQ & NORMAL_BITS)));

  // R6: abnormal summary agrees with visible words
  p_abn_sum_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[POS_ABN_SUM] == (|(statusQ & maskQ & ABNORMAL_BITS)));

  // R8: interrupt line agrees with enabled summaries
  p_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == (|(statusQ & maskQ & SUMMARY_BITS)));

  // R9: state fields hold without a load
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rxLoad |=> $stable(statusQ[RX_ST_LSB +: STATE_W]));
  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.txLoad |=> $stable(statusQ[TX_ST_LSB +: STATE_W]));

  // R10: enable word loads whole
  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskLoad |=> (maskQ == $past(strobes.maskVal)));
endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] evtSet,
  input  logic        hostWrEn,
  input  logic [31:0] hostWrData,
  input  logic        maskWrEn,
  input  logic [31:0] maskWrData,
  input  logic        rxStateWr,
  input  logic [2:0]  rxStateVal,
  input  logic        txStateWr,
  input  logic [2:0]  txStateVal,
  output logic [31:0] statusOut,
  output logic [31:0] maskOut,
  output logic        irqOut
);
  ctl_strobes_t strobes;

  isc_ctrl u_ctrl (
    .evtSet(evtSet), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .rxStateWr(rxStateWr), .rxStateVal(rxStateVal),
    .txStateWr(txStateWr), .txStateVal(txStateVal),
    .strobes(strobes));

  isc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .statusQ(statusOut), .maskQ(maskOut), .irqQ(irqOut));
endmodule

// File: tb/isc_top_tb_top.sv
module isc_top_tb_top;
  localparam logic [31:0] EV  = 32'h0C00_7FFF;
  localparam logic [31:0] NRM = 32'h0000_4845;
  localparam logic [31:0] ABN = 32'h0C00_37BA;
  localparam logic [31:0] SUM = 32'h0001_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] evtSet = '0, hostWrData = '0, maskWrData = '0;
  logic hostWrEn = 1'b0, maskWrEn = 1'b0, rxStateWr = 1'b0, txStateWr = 1'b0;
  logic [2:0] rxStateVal = '0, txStateVal = '0;
  logic [31:0] statusOut, maskOut;
  logic irqOut;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] mStatus = 32'hF000_0000, mMask = 32'hF3FE_0000;
  logic [31:0] qStat[$], qMask[$];
  logic qIrq[$];
  string qTag[$];

  always #2 clk = ~clk;

  isc_top dut_i (.*);

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [31:0] s, logic w, logic [31:0] wd, logic mw, logic [31:0] md,
                      logic rw, logic [2:0] rv, logic tw, logic [2:0] tv, string tag);
    logic [31:0] ev, ie;
    @(negedge clk);
    evtSet = s; hostWrEn = w; hostWrData = wd; maskWrEn = mw; maskWrData = md;
    rxStateWr = rw; rxStateVal = rv; txStateWr = tw; txStateVal = tv;
    if (mw) mMask = md;
    ev = mStatus & EV;
    if (w) ev = ev & ~(wd & EV);
    ev = ev | (s & EV);
    mStatus = (mStatus & 32'hF380_0000) | ev | (mStatus & 32'h007E_0000);
    if (rw) mStatus[19:17] = rv;
    if (tw) mStatus[22:20] = tv;
    ie = ev & mMask;
    mStatus[16] = |(ie & NRM);
    mStatus[15] = |(ie & ABN);
    qStat.push_back(mStatus);
    qMask.push_back(mMask);
    qIrq.push_back(|(mStatus & mMask & SUM));
    qTag.push_back(tag);
  endtask

  task automatic idle(string tag);
    step('0, 0, '0, 0, '0, 0, '0, 0, '0, tag);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qStat.size() > 0) begin
        string t;
        logic ei;
        t = qTag.pop_front();
        check32({t, " status"}, statusOut, qStat.pop_front());
        check32({t, " mask"}, maskOut, qMask.pop_front());
        ei = qIrq.pop_front();
        check32({t, " irq"}, {31'b0, irqOut}, {31'b0, ei});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check32("R1 reset status", statusOut, 32'hF000_0000);
    check32("R1 reset mask", maskOut, 32'hF3FE_0000);
    check32("R1 reset irq", {31'b0, irqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check32("R1 after release status", statusOut, 32'hF000_0000);

    step(32'h1, 0, '0, 0, '0, 0, 0, 0, 0, "R2 set unmasked event");
    step('0, 0, '0, 1, 32'h0001_0001, 0, 0, 0, 0, "R10 R5 R8 enable event and normal summary");
    step('0, 1, 32'h1, 0, '0, 0, 0, 0, 0, "R3 R7 clear event drops summary");
    step(32'hF3FF_8000, 0, '0, 0, '0, 0, 0, 0, 0, "R2 non-event strobes ignored");
    step(32'h80, 0, '0, 1, 32'h0000_8080, 0, 0, 0, 0, "R6 R8 abnormal event");
    step('0, 1, 32'h0000_8000, 0, '0, 0, 0, 0, 0, "R7 summary write-one while enabled");
    step('0, 0, '0, 1, 32'h0000_8000, 0, 0, 0, 0, "R7 disable event drops summary");
    step(32'h80, 1, 32'h80, 0, '0, 0, 0, 0, 0, "R4 set beats clear");
    step('0, 0, '0, 1, 32'h0000_0080, 0, 0, 0, 0, "R8 summary not enabled no irq");
    step('0, 0, '0, 0, '0, 1, 3'd5, 1, 3'd3, "R9 load both state fields");
    step('0, 0, '0, 0, '0, 1, 3'd2, 0, 0, "R9 replace receive field whole");
    step('0, 1, 32'hFFFF_FFFF, 0, '0, 0, 0, 0, 0, "R3 write all ones keeps fields and reserved");
    step('0, 0, '0, 0, '0, 0, 0, 1, 3'd0, "R9 clear transmit field");
    for (int b = 0; b < 32; b++) begin
      step(32'h1 << b, 0, '0, 1, (32'h1 << b) | SUM, 0, 0, 0, 0, "R2 R5 R6 R8 single event sweep");
      step('0, 1, 32'hFFFF_FFFF, 0, '0, 0, 0, 0, 0, "R3 sweep clear");
    end
    step(32'h0C00_7FFF, 0, '0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5 R6 all events enabled");
    step('0, 1, 32'h0000_4845, 0, '0, 0, 0, 0, 0, "R3 R5 clear normal group only");
    idle("R8 idle hold");
    idle("R8 idle settle");
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule